// File: doc/BRIEF.md
# UART Register File and Interrupt Combiner

This block is the software-visible front end of a simple UART. A bus master reaches it through a one-cycle request interface. Each access carries a byte address inside a 4 KiB window, and the block selects a register from that address shifted right by two. The block holds the configuration registers: divisors, line control, control, FIFO level select, DMA control and the interrupt mask. It keeps raw interrupt status and drives one registered interrupt line from status and mask. It also answers reads of an 8-byte identification table.

Data accesses go to neighbouring logic through simple handshakes. A data write presents a character to the transmit sink with a one-cycle valid pulse. A data read returns the receive FIFO head and pops it. The receive FIFO reports its state on status inputs, and it raises or drops the receive interrupt through set and clear pulses. Changing the FIFO enable bit in line control sends a flush pulse to the FIFO. Serial timing, baud generation, DMA and loopback are handled elsewhere.

Top module: `uart_regfile`

## Requirements
- R1: After reset, FIFO level select (word 13) reads 0x12, control (word 12) reads 0x300, line control, divisors, DMA control, mask and raw status read 0, and irq_o is low.
- R2: Writable registers hold and return only their low bits: low-power divisor word 8 (8 bits), integer divisor word 9 (16), fractional divisor word 10 (6), line control word 11 (8), control word 12 (16), level select word 13 (6), mask word 14 (11), DMA control word 18 (3).
- R3: A write to word 0 raises tx_valid_o in that cycle with tx_data_o equal to wdata bits 7:0, and sets raw status bit 5 at the clock edge that ends the access.
- R4: A read of word 0 returns rx_data_i zero-extended. It raises rx_pop_o in that cycle only when rx_empty_i is low. At that edge the receive status register (word 1, 4 bits) takes rx_data_i bits 11:8.
- R5: Any write to word 1 clears the receive status register.
- R6: Word 6 reads tx_empty_i at bit 7, rx_full_i at bit 6, tx_full_i at bit 5 and rx_empty_i at bit 4, with all other bits zero. Writes to it change no register.
- R7: A pulse on rx_set_i sets raw bit 4, and a pulse on rx_clr_i clears it. If rx_set_i arrives in the same cycle as a clear of bit 4, the bit ends up set.
- R8: A write to word 17 clears each raw status bit whose bit is one in wdata and leaves the other bits unchanged.
- R9: Word 15 reads raw status, and word 16 reads raw status AND mask.
- R10: irq_o is a register equal to the OR of raw status AND mask. It takes its new value at the same edge as the access or pulse that changes either operand.
- R11: Word offsets 0x3F8 to 0x3FF (byte 0xFE0 to 0xFFC) read in order 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Reads of unassigned word offsets return 0. Writes to unassigned or read-only offsets (15, 16, ID) have no effect.
- R13: fifo_en_o follows line control bit 4. A line control write that flips bit 4 raises fifo_flush_o in that cycle, and a write that keeps bit 4 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Combined interrupt, registered |
| tx_valid_o | output | 1 | Character valid to transmit sink |
| tx_data_o | output | 8 | Character to transmit |
| rx_data_i | input | 12 | Receive FIFO head: error bits 11:8, character 7:0 |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_pop_o | output | 1 | Pop receive FIFO head |
| tx_full_i | input | 1 | Transmit path full |
| tx_empty_i | input | 1 | Transmit path empty |
| rx_set_i | input | 1 | Receive interrupt set pulse |
| rx_clr_i | input | 1 | Receive interrupt clear pulse |
| fifo_en_o | output | 1 | FIFO enable to receive FIFO |
| fifo_flush_o | output | 1 | Flush pulse on FIFO enable change |

## Verification
The bench targets the race between a hardware receive-interrupt set and a software clear in the same cycle. A design that gives the clear priority would drop a pending receive event. It checks that a clear write leaves unselected raw bits alone, which a design that clears the whole register would fail. It checks that irq_o moves at the edge of the mask or clear write, and not one cycle later. Writes to the flag, status and unassigned offsets are followed by read-back of neighbouring registers, so that a loose decode that aliases them shows up as corrupted configuration. A pop while the receive FIFO is empty is also checked, along with a flush pulse raised when the enable bit has not changed.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int WOFF_W   = ADDR_W - 2;
  localparam int IRQ_W    = 11;
  localparam int RX_W     = 12;
  localparam int CHAR_W   = 8;
  localparam int RSR_W    = RX_W - CHAR_W;
  localparam int ILPR_W   = 8;
  localparam int IBRD_W   = 16;
  localparam int FBRD_W   = 6;
  localparam int LCR_W    = 8;
  localparam int CR_W     = 16;
  localparam int IFLS_W   = 6;
  localparam int DMA_W    = 3;
  localparam int ID_N     = 8;
  localparam int ID_IDX_W = $clog2(ID_N);

  localparam int IRQ_TX_BIT  = 5;
  localparam int IRQ_RX_BIT  = 4;
  localparam int LCR_FEN_BIT = 4;

  localparam logic [IFLS_W-1:0] IFLS_RST = 6'h12;
  localparam logic [CR_W-1:0]   CR_RST   = 16'h0300;

  localparam logic [WOFF_W-1:0] ID_BASE = 10'h3F8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_RSR, SEL_FLAG, SEL_ILPR, SEL_IBRD, SEL_FBRD, SEL_LCR,
    SEL_CR, SEL_IFLS, SEL_IMSC, SEL_RIS, SEL_MIS, SEL_ICR, SEL_DMA, SEL_ID
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 8'h11;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  output reg_sel_e            sel_o,
  output logic [ID_IDX_W-1:0] id_idx_o
);
  logic [WOFF_W-1:0] woff;
  logic              unused_lsb;

  assign woff       = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign id_idx_o   = woff[ID_IDX_W-1:0];

  always_comb begin
    if (woff >= ID_BASE) begin
      sel_o = SEL_ID;
    end else begin
      case (woff)
        10'd0:   sel_o = SEL_DATA;
        10'd1:   sel_o = SEL_RSR;
        10'd6:   sel_o = SEL_FLAG;
        10'd8:   sel_o = SEL_ILPR;
        10'd9:   sel_o = SEL_IBRD;
        10'd10:  sel_o = SEL_FBRD;
        10'd11:  sel_o = SEL_LCR;
        10'd12:  sel_o = SEL_CR;
        10'd13:  sel_o = SEL_IFLS;
        10'd14:  sel_o = SEL_IMSC;
        10'd15:  sel_o = SEL_RIS;
        10'd16:  sel_o = SEL_MIS;
        10'd17:  sel_o = SEL_ICR;
        10'd18:  sel_o = SEL_DMA;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
  import uart_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ILPR_W-1:0] ilpr_o,
  output logic [IBRD_W-1:0] ibrd_o,
  output logic [FBRD_W-1:0] fbrd_o,
  output logic [LCR_W-1:0]  lcr_o,
  output logic [CR_W-1:0]   cr_o,
  output logic [IFLS_W-1:0] ifls_o,
  output logic [DMA_W-1:0]  dma_o,
  output logic              fifo_flush_o
);
  assign fifo_flush_o = wr_en_i && (sel_i == SEL_LCR) &&
                        (lcr_o[LCR_FEN_BIT] != wdata_i[LCR_FEN_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ilpr_o <= '0;
      ibrd_o <= '0;
      fbrd_o <= '0;
      lcr_o  <= '0;
      cr_o   <= CR_RST;
      ifls_o <= IFLS_RST;
      dma_o  <= '0;
    end else if (wr_en_i) begin
      case (sel_i)
        SEL_ILPR: ilpr_o <= wdata_i[ILPR_W-1:0];
        SEL_IBRD: ibrd_o <= wdata_i[IBRD_W-1:0];
        SEL_FBRD: fbrd_o <= wdata_i[FBRD_W-1:0];
        SEL_LCR:  lcr_o  <= wdata_i[LCR_W-1:0];
        SEL_CR:   cr_o   <= wdata_i[CR_W-1:0];
        SEL_IFLS: ifls_o <= wdata_i[IFLS_W-1:0];
        SEL_DMA:  dma_o  <= wdata_i[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  // R6
  flag_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_FLAG) |=> ($stable(lcr_o) && $stable(cr_o) && $stable(ifls_o)));

  // R13
  flush_toggles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_flush_o |=> (lcr_o[LCR_FEN_BIT] != $past(lcr_o[LCR_FEN_BIT])));
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] wdata_i,
  input  logic             tx_set_i,
  input  logic             rx_set_i,
  input  logic             rx_clr_i,
  output logic [IRQ_W-1:0] ris_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] ris_d, mask_d;

  always_comb begin
    ris_d = ris_o;
    if (clr_we_i) ris_d = ris_d & ~wdata_i;
    if (rx_clr_i) ris_d[IRQ_RX_BIT] = 1'b0;
    // hardware sets win over clears in the same cycle
    if (tx_set_i) ris_d[IRQ_TX_BIT] = 1'b1;
    if (rx_set_i) ris_d[IRQ_RX_BIT] = 1'b1;
    mask_d = mask_we_i ? wdata_i : mask_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ris_o  <= '0;
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      ris_o  <= ris_d;
      mask_o <= mask_d;
      irq_o  <= |(ris_d & mask_d);
    end
  end

  // R10
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(ris_o & mask_o)));

  // R3
  tx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_set_i |=> ris_o[IRQ_TX_BIT]);

  // R7
  rx_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_set_i |=> ris_o[IRQ_RX_BIT]);

  // R8
  clr_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && wdata_i[IRQ_TX_BIT] && !tx_set_i) |=> !ris_o[IRQ_TX_BIT]);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [CHAR_W-1:0] tx_data_o,
  input  logic [RX_W-1:0]   rx_data_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  output logic              rx_pop_o,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic              rx_set_i,
  input  logic              rx_clr_i,
  output logic              fifo_en_o,
  output logic              fifo_flush_o
);
  reg_sel_e            sel;
  logic [ID_IDX_W-1:0] id_idx;
  logic                wr_en, rd_en;
  logic [RSR_W-1:0]    rsr_q;
  logic [ILPR_W-1:0]   ilpr;
  logic [IBRD_W-1:0]   ibrd;
  logic [FBRD_W-1:0]   fbrd;
  logic [LCR_W-1:0]    lcr;
  logic [CR_W-1:0]     cr;
  logic [IFLS_W-1:0]   ifls;
  logic [DMA_W-1:0]    dma;
  logic [IRQ_W-1:0]    ris, mask;
  logic [7:0]          flags;

  assign wr_en = req_i && we_i;
  assign rd_en = req_i && !we_i;

  uart_rf_decode u_decode (
    .addr_i   (addr_i),
    .sel_o    (sel),
    .id_idx_o (id_idx)
  );

  uart_rf_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .sel_i        (sel),
    .wdata_i      (wdata_i),
    .ilpr_o       (ilpr),
    .ibrd_o       (ibrd),
    .fbrd_o       (fbrd),
    .lcr_o        (lcr),
    .cr_o         (cr),
    .ifls_o       (ifls),
    .dma_o        (dma),
    .fifo_flush_o (fifo_flush_o)
  );

  uart_rf_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (wr_en && sel == SEL_IMSC),
    .clr_we_i  (wr_en && sel == SEL_ICR),
    .wdata_i   (wdata_i[IRQ_W-1:0]),
    .tx_set_i  (tx_valid_o),
    .rx_set_i  (rx_set_i),
    .rx_clr_i  (rx_clr_i),
    .ris_o     (ris),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  assign tx_valid_o = wr_en && (sel == SEL_DATA);
  assign tx_data_o  = wdata_i[CHAR_W-1:0];
  assign rx_pop_o   = rd_en && (sel == SEL_DATA) && !rx_empty_i;
  assign fifo_en_o  = lcr[LCR_FEN_BIT];
  assign flags      = {tx_empty_i, rx_full_i, tx_full_i, rx_empty_i, 4'b0000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rsr_q <= '0;
    else if (wr_en && sel == SEL_RSR)     rsr_q <= '0;
    else if (rd_en && sel == SEL_DATA)    rsr_q <= rx_data_i[RX_W-1:CHAR_W];
  end

  always_comb begin
    case (sel)
      SEL_DATA: rdata_o = DATA_W'(rx_data_i);
      SEL_RSR:  rdata_o = DATA_W'(rsr_q);
      SEL_FLAG: rdata_o = DATA_W'(flags);
      SEL_ILPR: rdata_o = DATA_W'(ilpr);
      SEL_IBRD: rdata_o = DATA_W'(ibrd);
      SEL_FBRD: rdata_o = DATA_W'(fbrd);
      SEL_LCR:  rdata_o = DATA_W'(lcr);
      SEL_CR:   rdata_o = DATA_W'(cr);
      SEL_IFLS: rdata_o = DATA_W'(ifls);
      SEL_IMSC: rdata_o = DATA_W'(mask);
      SEL_RIS:  rdata_o = DATA_W'(ris);
      SEL_MIS:  rdata_o = DATA_W'(ris & mask);
      SEL_DMA:  rdata_o = DATA_W'(dma);
      SEL_ID:   rdata_o = DATA_W'(id_byte(id_idx));
      default:  rdata_o = '0;
    endcase
  end

  // R5
  rsr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && sel == SEL_RSR) |=> (rsr_q == '0));

  // R4
  no_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !rx_empty_i);

  // R4
  rsr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && sel == SEL_DATA) |=> (rsr_q == $past(rx_data_i[RX_W-1:CHAR_W])));
endmodule

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, tx_valid_o, rx_pop_o, fifo_en_o, fifo_flush_o;
  logic [7:0]  tx_data_o;
  logic [11:0] rx_data_i = '0;
  logic        rx_empty_i = 1'b1, rx_full_i = 1'b0;
  logic        tx_full_i = 1'b0, tx_empty_i = 1'b1;
  logic        rx_set_i = 1'b0, rx_clr_i = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // capture of same-cycle outputs during the last access
  logic        cap_txv, cap_pop, cap_flush;
  logic [7:0]  cap_txd;
  logic [31:0] rd;

  always #10 clk_i = ~clk_i;

  uart_regfile u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o,
    .tx_valid_o, .tx_data_o, .rx_data_i, .rx_empty_i, .rx_full_i, .rx_pop_o,
    .tx_full_i, .tx_empty_i, .rx_set_i, .rx_clr_i, .fifo_en_o, .fifo_flush_o
  );

  // {we, addr, wdata, expected read}
  localparam logic [76:0] VEC [16] = '{
    {1'b1, 12'h020, 32'h0000_01A5, 32'h0},
    {1'b1, 12'h024, 32'h0001_2345, 32'h0},
    {1'b1, 12'h028, 32'h0000_00FF, 32'h0},
    {1'b1, 12'h02C, 32'h0000_0160, 32'h0},
    {1'b1, 12'h030, 32'hFFFF_0301, 32'h0},
    {1'b1, 12'h034, 32'h0000_01C5, 32'h0},
    {1'b1, 12'h048, 32'h0000_000F, 32'h0},
    {1'b1, 12'h038, 32'hFFFF_F800, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0000_00A5},
    {1'b0, 12'h024, 32'h0, 32'h0000_2345},
    {1'b0, 12'h028, 32'h0, 32'h0000_003F},
    {1'b0, 12'h02C, 32'h0, 32'h0000_0060},
    {1'b0, 12'h030, 32'h0, 32'h0000_0301},
    {1'b0, 12'h034, 32'h0, 32'h0000_0005},
    {1'b0, 12'h048, 32'h0, 32'h0000_0007},
    {1'b0, 12'h038, 32'h0, 32'h0000_0000}
  };

  localparam logic [7:0] ID_EXP [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    #2;
    cap_txv = tx_valid_o; cap_txd = tx_data_o; cap_flush = fifo_flush_o;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #2;
    d = rdata_o; cap_pop = rx_pop_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1", "irq", 32'(irq_o), 32'h0);
    bus_rd(12'h034, rd); chk("R1", "ifls", rd, 32'h12);
    bus_rd(12'h030, rd); chk("R1", "cr", rd, 32'h300);
    bus_rd(12'h02C, rd); chk("R1", "lcr", rd, 32'h0);
    bus_rd(12'h038, rd); chk("R1", "mask", rd, 32'h0);
    bus_rd(12'h03C, rd); chk("R1", "raw", rd, 32'h0);
    bus_rd(12'h024, rd); chk("R1", "ibrd", rd, 32'h0);

    // R2 vector walk
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][76]) bus_wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][75:64], rd);
        chk("R2", $sformatf("readback 0x%0h", VEC[i][75:64]), rd, VEC[i][31:0]);
      end
    end

    // R6 flags
    bus_rd(12'h018, rd); chk("R6", "flags idle", rd, 32'h90);
    bus_wr(12'h018, 32'hFFFF_FFFF);
    bus_rd(12'h018, rd); chk("R6", "flags after write", rd, 32'h90);
    bus_rd(12'h030, rd); chk("R6", "cr after flag write", rd, 32'h301);
    rx_full_i = 1'b1; tx_full_i = 1'b1; tx_empty_i = 1'b0; rx_empty_i = 1'b0;
    bus_rd(12'h018, rd); chk("R6", "flags busy", rd, 32'h60);
    rx_full_i = 1'b0; tx_full_i = 1'b0; tx_empty_i = 1'b1; rx_empty_i = 1'b1;

    // R3 data write
    bus_wr(12'h000, 32'h0000_01C3);
    chk("R3", "tx_valid", 32'(cap_txv), 32'h1);
    chk("R3", "tx_data", 32'(cap_txd), 32'hC3);
    bus_rd(12'h03C, rd); chk("R3", "raw tx bit", rd, 32'h20);
    chk("R10", "irq masked off", 32'(irq_o), 32'h0);
    bus_wr(12'h020, 32'h11);
    chk("R3", "no tx_valid on other write", 32'(cap_txv), 32'h0);

    // R10/R9 mask
    bus_wr(12'h038, 32'h20);
    chk("R10", "irq after mask write", 32'(irq_o), 32'h1);
    bus_rd(12'h040, rd); chk("R9", "masked", rd, 32'h20);

    // R8 clear
    bus_wr(12'h044, 32'h10);
    bus_rd(12'h03C, rd); chk("R8", "unselected bit kept", rd, 32'h20);
    bus_wr(12'h044, 32'h20);
    chk("R10", "irq after clear", 32'(irq_o), 32'h0);
    bus_rd(12'h03C, rd); chk("R8", "tx bit cleared", rd, 32'h0);

    // R7 receive set/clear
    @(negedge clk_i); rx_set_i = 1'b1;
    @(negedge clk_i); rx_set_i = 1'b0;
    bus_rd(12'h03C, rd); chk("R7", "rx set", rd, 32'h10);
    chk("R10", "irq rx unmasked off", 32'(irq_o), 32'h0);
    bus_wr(12'h038, 32'h30);
    chk("R10", "irq rx masked on", 32'(irq_o), 32'h1);
    bus_rd(12'h040, rd); chk("R9", "masked rx", rd, 32'h10);
    @(negedge clk_i); rx_clr_i = 1'b1;
    @(negedge clk_i); rx_clr_i = 1'b0;
    chk("R10", "irq after rx clear pulse", 32'(irq_o), 32'h0);
    bus_rd(12'h03C, rd); chk("R7", "rx cleared", rd, 32'h0);

    // R7 set beats software clear
    @(negedge clk_i);
    rx_set_i = 1'b1; req_i = 1'b1; we_i = 1'b1; addr_i = 12'h044; wdata_i = 32'h10;
    @(negedge clk_i);
    rx_set_i = 1'b0; req_i = 1'b0; we_i = 1'b0;
    bus_rd(12'h03C, rd); chk("R7", "set wins over clear", rd, 32'h10);
    chk("R10", "irq after race", 32'(irq_o), 32'h1);
    bus_wr(12'h044, 32'h7FF);
    chk("R10", "irq after clear all", 32'(irq_o), 32'h0);

    // R4/R5 receive data
    rx_empty_i = 1'b0; rx_data_i = 12'h5A7;
    bus_rd(12'h000, rd);
    chk("R4", "rx data", rd, 32'h5A7);
    chk("R4", "pop", 32'(cap_pop), 32'h1);
    bus_rd(12'h004, rd); chk("R4", "rsr captured", rd, 32'h5);
    bus_wr(12'h004, 32'h0);
    bus_rd(12'h004, rd); chk("R5", "rsr cleared", rd, 32'h0);
    rx_empty_i = 1'b1;
    bus_rd(12'h000, rd); chk("R4", "no pop when empty", 32'(cap_pop), 32'h0);
    rx_data_i = '0;

    // R11 id table
    for (int i = 0; i < 8; i++) begin
      bus_rd(12'(12'hFE0 + 4 * i), rd);
      chk("R11", $sformatf("id %0d", i), rd, 32'(ID_EXP[i]));
    end

    // R12 undefined and read-only offsets
    bus_wr(12'h04C, 32'hFFFF_FFFF);
    bus_wr(12'h03C, 32'h7FF);
    bus_wr(12'h040, 32'h7FF);
    bus_wr(12'hFE0, 32'hFF);
    chk("R12", "irq unchanged", 32'(irq_o), 32'h0);
    bus_rd(12'h03C, rd); chk("R12", "raw unchanged", rd, 32'h0);
    bus_rd(12'h038, rd); chk("R12", "mask unchanged", rd, 32'h30);
    bus_rd(12'h030, rd); chk("R12", "cr unchanged", rd, 32'h301);
    bus_rd(12'hFE0, rd); chk("R12", "id unchanged", rd, 32'h11);
    bus_rd(12'h008, rd); chk("R12", "read 0x008", rd, 32'h0);
    bus_rd(12'h00C, rd); chk("R12", "read 0x00C", rd, 32'h0);
    bus_rd(12'h04C, rd); chk("R12", "read 0x04C", rd, 32'h0);
    bus_rd(12'hFDC, rd); chk("R12", "read 0xFDC", rd, 32'h0);

    // R13 FIFO enable and flush
    chk("R13", "fifo_en before", 32'(fifo_en_o), 32'h0);
    bus_wr(12'h02C, 32'h70);
    chk("R13", "flush on toggle", 32'(cap_flush), 32'h1);
    chk("R13", "fifo_en after", 32'(fifo_en_o), 32'h1);
    bus_wr(12'h02C, 32'h72);
    chk("R13", "no flush when kept", 32'(cap_flush), 32'h0);
    bus_wr(12'h02C, 32'h02);
    chk("R13", "flush on disable", 32'(cap_flush), 32'h1);
    chk("R13", "fifo_en off", 32'(fifo_en_o), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule